// File: doc/BRIEF.md
# Streaming Trapezoidal Integrator

This block is a running numerical integrator for a stream of signed fixed-point samples. For every accepted sample it produces the trapezoidal-rule area over the most recent NTAPS samples. The end samples of the window get half the step weight and every sample between them gets the full step weight. The structure is a transposed FIR filter: each sample is broadcast to all tap products at once, and partial sums move one tap per accepted sample through a chain of registers. This keeps the adder path to a single addition whatever the tap count.

Two pipeline cuts shorten the clock period. Each tap product is split into a low-half and a high-half partial product with a register after the split. A second register sits on the feed-forward cutset between the products and the adder chain. The step size is 2^STEP_LOG2 sample periods. `out_sum` carries one fractional bit, so it equals twice the integral: out_sum = 2^STEP_LOG2 * (x[n] + 2*x[n-1] + ... + 2*x[n-NTAPS+2] + x[n-NTAPS+1]). The accumulator is DW + log2(NTAPS) + 1 + STEP_LOG2 bits wide, so no sum can wrap. The chain and the output advance only for accepted samples, so idle cycles between samples do not change the result.

Top module: `trapint_top`

## Requirements
- R1: Each end tap of the window carries weight 2^STEP_LOG2 and each interior tap carries weight 2^(STEP_LOG2+1). A single sample of value 1 inside a stream of zeros therefore produces the output sequence 1, 2, ..., 2, 1 (times 2^STEP_LOG2) as the window slides past it.
- R2: For an unbroken stream of accepted samples, every valid output equals the weighted sum of R1 over the last NTAPS accepted samples, with the newest sample at one end of the window.
- R3: `out_valid` for an accepted sample is high in the cycle that follows the third rising edge, counting the edge that captured `in_valid`. In that cycle `out_sum` holds the matching result.
- R4: After reset, `out_valid` stays low until NTAPS samples have been accepted. The NTAPS-th sample is the first one to produce a valid output.
- R5: Cycles with `in_valid` low do not advance the window. A stream with idle gaps gives the same sequence of results as the same samples sent back to back.
- R6: Full-scale inputs (all samples at the most positive value, or all at the most negative value) give the exact sum with no wrap.
- R7: A synchronous active-high reset clears all pipeline and window state. During reset and in the cycle after it, `out_valid` is 0 and `out_sum` is 0. The window then refills from empty.
- R8: Each tap's product is rebuilt from its two half-width partial products and equals the sample times the tap weight. The low half of the sample is treated as unsigned and the high half as signed.
- R9: `out_sum` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The sample on `in_sample` is accepted at this edge |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | `out_sum` holds a new window result |
| out_sum | output | DW+$clog2(NTAPS)+1+STEP_LOG2 | Signed window integral, with one fractional bit |

## Verification
The assertions assume that `rst` is held high from time zero for at least one rising edge. They also assume that `in_sample` is a defined value at every edge where `in_valid` is high. The product check assumes that the sample stays defined in the two cycles before it is used, which holds because the stimulus always drives the sample to a known value, including the cycles when the sample is not accepted. The stimulus changes inputs only on falling edges. It never issues a reset while a check depends on samples older than that reset. It mixes random values with directed patterns such as full-scale values, impulses and half-word boundary values, so every accumulator sum stays inside the range the assertions rely on.

// File: rtl/trapint_pkg.sv
package trapint_pkg;

  // Width of the accumulator: sample, tap growth, guard bit, step scaling.
  function automatic int acc_width(input int dw, input int ntaps, input int step_log2);
    return dw + $clog2(ntaps) + 1 + step_log2;
  endfunction

  // A tap sits at an end of the trapezoid window.
  function automatic bit tap_is_edge(input int k, input int ntaps);
    return (k == 0) || (k == ntaps - 1);
  endfunction

  // Integer weight in units of half a step: ends 1, interior 2, scaled by the step.
  function automatic int tap_weight(input int k, input int ntaps, input int step_log2);
    return (tap_is_edge(k, ntaps) ? 1 : 2) << step_log2;
  endfunction

endpackage

// File: rtl/trapint_split_mul.sv
module trapint_split_mul #(
  parameter int DW     = 16,
  parameter int PW     = 20,
  parameter int WEIGHT = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        x,
  output logic signed [PW-1:0] prod
);
  localparam int LOW_W  = DW / 2;
  localparam int HIGH_W = DW - LOW_W;
  localparam logic signed [PW-1:0] WCONST = PW'(WEIGHT);

  logic signed [PW-1:0] low_ext, high_ext;
  logic signed [PW-1:0] low_pp, high_pp;

  assign low_ext  = $signed({{(PW-LOW_W){1'b0}}, x[LOW_W-1:0]});
  assign high_ext = $signed({{(PW-HIGH_W){x[DW-1]}}, x[DW-1:LOW_W]});

  // Stage one: two half-width partial products.
  always_ff @(posedge clk) begin
    if (rst) begin
      low_pp  <= '0;
      high_pp <= '0;
    end else begin
      low_pp  <= low_ext * WCONST;
      high_pp <= high_ext * WCONST;
    end
  end

  // Stage two: recombine on the feed-forward cutset.
  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= (high_pp <<< LOW_W) + low_pp;
  end

  // Checker state: cycles since reset, saturating at the pipeline depth.
  logic [1:0]           chk_age;
  logic signed [PW-1:0] x_full;
  assign x_full = $signed({{(PW-DW){x[DW-1]}}, x});

  always_ff @(posedge clk) begin
    if (rst)                chk_age <= 2'd0;
    else if (chk_age != 2'd2) chk_age <= chk_age + 2'd1;
  end

  AST_SPLIT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (chk_age == 2'd2) |-> (prod == $past(x_full, 2) * WCONST)); // R8

endmodule

// File: rtl/trapint_fill_ctl.sv
module trapint_fill_ctl #(
  parameter int NTAPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic chain_en,
  output logic out_en,
  output logic out_valid
);
  localparam int CW  = $clog2(NTAPS);
  localparam int SW  = $clog2(NTAPS + 1);

  logic          stage1_v, stage2_v;
  logic [CW-1:0] fill_cnt;
  logic          window_full;

  assign window_full = (fill_cnt == CW'(NTAPS - 1));
  assign chain_en    = stage2_v;
  assign out_en      = stage2_v && window_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_v  <= 1'b0;
      stage2_v  <= 1'b0;
      out_valid <= 1'b0;
      fill_cnt  <= '0;
    end else begin
      stage1_v  <= in_valid;
      stage2_v  <= stage1_v;
      out_valid <= out_en;
      if (stage2_v && !window_full) fill_cnt <= fill_cnt + CW'(1);
    end
  end

  // Independent count of samples taken at the input since reset.
  logic [SW-1:0] chk_seen;
  always_ff @(posedge clk) begin
    if (rst)                                       chk_seen <= '0;
    else if (in_valid && chk_seen != SW'(NTAPS))   chk_seen <= chk_seen + SW'(1);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3)); // R3

  AST_FULL_WINDOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (chk_seen == SW'(NTAPS))); // R4

endmodule

// File: rtl/trapint_top.sv
module trapint_top
  import trapint_pkg::*;
#(
  parameter int  DW        = 16,
  parameter int  NTAPS     = 8,
  parameter int  STEP_LOG2 = 0,
  localparam int AW        = acc_width(DW, NTAPS, STEP_LOG2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_sample,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_sum
);
  logic                 chain_en, out_en;
  logic signed [AW-1:0] prod  [NTAPS];
  logic signed [AW-1:0] chain [NTAPS];
  logic signed [AW-1:0] tail  [NTAPS];
  logic signed [AW:0]   head_wide;

  trapint_fill_ctl #(.NTAPS(NTAPS)) u_fill (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .chain_en (chain_en),
    .out_en   (out_en),
    .out_valid(out_valid)
  );

  // Broadcast the sample to every tap product.
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    trapint_split_mul #(
      .DW    (DW),
      .PW    (AW),
      .WEIGHT(tap_weight(k, NTAPS, STEP_LOG2))
    ) u_mul (
      .clk (clk),
      .rst (rst),
      .x   (in_sample),
      .prod(prod[k])
    );
    if (k == NTAPS - 1) begin : g_last
      assign tail[k] = '0;
    end else begin : g_mid
      assign tail[k] = chain[k+1];
    end
  end

  assign head_wide = {prod[0][AW-1], prod[0]} + {tail[0][AW-1], tail[0]};

  // Transposed adder chain; index 0 is the output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAPS; k++) chain[k] <= '0;
    end else begin
      if (chain_en) begin
        for (int k = 1; k < NTAPS; k++) chain[k] <= prod[k] + tail[k];
      end
      if (out_en) chain[0] <= head_wide[AW-1:0];
    end
  end

  assign out_sum = chain[0];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (head_wide[AW] == head_wide[AW-1])); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_sum)); // R9

endmodule

// File: tb/trapint_top_tb.sv
module trapint_top_tb_top;
  localparam int DW        = 16;
  localparam int NTAPS     = 8;
  localparam int STEP_LOG2 = 0;
  localparam int AW        = DW + $clog2(NTAPS) + 1 + STEP_LOG2;

  logic                 clk = 1'b0;
  logic                 rst;
  logic                 in_valid;
  logic [DW-1:0]        in_sample;
  logic                 out_valid;
  logic signed [AW-1:0] out_sum;

  trapint_top #(.DW(DW), .NTAPS(NTAPS), .STEP_LOG2(STEP_LOG2)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  always #10 clk = ~clk;

  int     checks = 0;
  int     fails  = 0;
  int     cyc    = 0;
  bit     done   = 1'b0;
  string  cur_req = "R7";
  longint hist [NTAPS];
  int     n_acc  = 0;
  longint hold   = 0;
  bit     exp_v [8];
  longint exp_s [8];

  // Reference: twice the plain sum, less the two end samples, times the step.
  function automatic longint win_sum();
    longint total = 0;
    for (int i = 0; i < NTAPS; i++) total += hist[i];
    return (2 * total - hist[0] - hist[NTAPS-1]) * (longint'(1) << STEP_LOG2);
  endfunction

  // Model: track accepted samples and schedule the expected output.
  always @(posedge clk) begin : model
    bit v;
    cyc++;
    if (rst) begin
      for (int i = 0; i < NTAPS; i++) hist[i] = 0;
      n_acc = 0;
      hold  = 0;
      for (int d = 0; d < 3; d++) begin
        exp_v[(cyc+d)%8] = 1'b0;
        exp_s[(cyc+d)%8] = 0;
      end
    end else begin
      v = 1'b0;
      if (in_valid) begin
        for (int i = NTAPS-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'($signed(in_sample));
        n_acc++;
        if (n_acc >= NTAPS) begin
          hold = win_sum();
          v = 1'b1;
        end
      end
      exp_v[(cyc+2)%8] = v;
      exp_s[(cyc+2)%8] = hold;
    end
  end

  // Monitor, away from the active edge.
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      checks++;
      if (out_valid !== exp_v[cyc%8] || longint'(out_sum) !== exp_s[cyc%8]) begin
        fails++;
        $display("FAIL %s cycle %0d: out_valid=%0d out_sum=%0d expected valid=%0d sum=%0d",
                 cur_req, cyc, out_valid, longint'(out_sum), exp_v[cyc%8], exp_s[cyc%8]);
      end
    end
  end

  task automatic do_reset(input int n);
    rst = 1'b1; in_valid = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] v);
    in_sample = v; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_sample = DW'($urandom);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed01));
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    @(negedge clk);
    // R7: reset state
    cur_req = "R7";
    do_reset(3);
    idle(3);
    // R4: no valid output before the window holds NTAPS samples
    cur_req = "R4";
    for (int i = 0; i < NTAPS-1; i++) push(DW'($urandom));
    idle(6);
    push(DW'($urandom));
    idle(4);
    // R1: impulse response shows trapezoid weights
    cur_req = "R1";
    do_reset(2);
    for (int i = 0; i < NTAPS-1; i++) push('0);
    push(DW'(1));
    for (int i = 0; i < NTAPS+1; i++) push('0);
    idle(4);
    // R2: random back-to-back stream
    cur_req = "R2";
    for (int i = 0; i < 300; i++) push(DW'($urandom));
    idle(4);
    // R3: isolated samples with long idles, exact latency
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin
      push(DW'($urandom));
      idle(5);
    end
    // R5: random gaps between samples
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      push(DW'($urandom));
      idle($urandom % 4);
    end
    idle(4);
    // R6: full-scale positive and negative runs
    cur_req = "R6";
    for (int i = 0; i < 2*NTAPS; i++) push(16'h7FFF);
    for (int i = 0; i < 2*NTAPS; i++) push(16'h8000);
    for (int i = 0; i < 2*NTAPS; i++) push(16'h7FFF);
    idle(4);
    // R7: reset while samples are in flight, then refill
    cur_req = "R7";
    push(DW'($urandom));
    push(DW'($urandom));
    do_reset(1);
    idle(3);
    for (int i = 0; i < NTAPS+4; i++) push(DW'($urandom));
    idle(4);
    // R8: half-word boundary patterns in the split products
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      push(16'h80FF); push(16'h00FF); push(16'hFF00); push(16'h7F80);
      push(16'hFFFF); push(16'h0100); push(16'h8001); push(16'h00FF);
    end
    for (int i = 0; i < 100; i++) push({DW/2{2'b10}} ^ DW'($urandom % 256));
    idle(4);
    // R9: output held across a long idle stretch
    cur_req = "R9";
    push(DW'($urandom));
    idle(30);
    push(DW'($urandom));
    idle(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule